// File: doc/BRIEF.md
# Buffered UART with status flags

This block is a serial transmitter and receiver placed behind a small bus-style register window. Address 0 carries the character data and works in two directions. A write stores one character in a transmit holding buffer. That buffer feeds a transmit shift register. A read returns the oldest character held in a two-entry receive FIFO and removes it from the FIFO. Address 1 is the status register. It shows three flags: receive-complete, transmit-complete and data-register-empty.

Line timing comes from a fixed divider. The divider produces one oversampling tick every `CLK_DIV` clocks, and one bit lasts 16 ticks. Each frame has one start bit, 5 to 8 data bits sent least significant bit first, no parity, and one stop bit. Software writes a character only when the empty flag is set. It reads characters while the receive-complete flag is set. It clears the transmit-complete flag by writing a one to that flag's bit. A hardware acknowledge pulse also clears the transmit-complete flag.

Top module: `uart_bc_top`

## Requirements
- R1: When `tx_en` is high and no frame is in progress, a character held in the holding buffer is sent on `txd`. The frame is one low start bit, then the data bits least significant bit first, then one high stop bit. Between frames `txd` stays high.
- R2: A write to address 0 while the data-register-empty flag is 0 is discarded. The character already pending is the one transmitted.
- R3: The data-register-empty flag is status bit 5. It falls after a write to address 0 that is accepted. It rises when the holding buffer moves into the shift register. That move happens only while `tx_en` is high.
- R4: The transmit-complete flag is status bit 6. It is set when the stop bit of a frame ends and the holding buffer is empty. It is cleared by a status write with bit 6 set, or by a `txc_ack` pulse. If a set and a clear fall in the same cycle, the set wins.
- R5: `char_len` selects the number of data bits: 0 means 5, 1 means 6, 2 means 7 and 3 means 8. The transmitter ignores the unused upper bits. The receiver returns those bits as 0.
- R6: A read of address 0 returns the oldest received character and pops it. Characters come out in arrival order.
- R7: The receive-complete flag is status bit 7. It is 1 while the receive FIFO holds at least one character and 0 when the FIFO is empty.
- R8: A character that finishes while both FIFO entries are full, with no read in the same cycle, is dropped. The two stored characters are kept.
- R9: While `rx_en` is low, the receive FIFO is emptied and the receiver stays idle. The receive-complete flag reads 0.
- R10: The receiver samples a falling edge on `rxd` again at the middle of the start bit. If the line is high again at that point, the edge is rejected and no character is produced.
- R11: After reset, the status register reads 0x20, `txd` is high, and status bits 4 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | 0: data, 1: status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops the FIFO when `bus_addr` is 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`; combinational |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes the FIFO |
| char_len | input | 2 | Data bits per character minus 5 |
| txc_ack | input | 1 | Clears the transmit-complete flag |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
Two events can land in the same cycle: the end of a frame sets transmit-complete, and an acknowledge clears it. The bench provokes this by holding `txc_ack` high for a whole frame. Meanwhile it samples the status register every cycle. The flag must be seen high for exactly one cycle, which shows that the set won over the constant clear. The checker separately asserts that every frame end with an empty holding buffer leaves the flag set in the next cycle.

// File: rtl/uart_bc_pkg.sv
package uart_bc_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // number of data bits for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // clear the bits above the selected character length
  function automatic logic [7:0] char_mask(input logic [7:0] d, input logic [1:0] len);
    return d & (8'hFF >> (2'd3 - len));
  endfunction

  // line level for frame position idx (0 start, 1..nb data, then stop)
  function automatic logic frame_bit(input logic [7:0] sh, input logic [3:0] idx,
                                     input logic [3:0] nb);
    logic [3:0] k;
    k = idx - 4'd1;
    if (idx == 4'd0) return 1'b0;
    else if (idx <= nb) return sh[k[2:0]];
    else return 1'b1;
  endfunction

  // right-align bits that were shifted in from the top
  function automatic logic [7:0] rx_align(input logic [7:0] sh, input logic [1:0] len);
    return sh >> (2'd3 - len);
  endfunction

endpackage

// File: rtl/uart_bc_tick.sv
module uart_bc_tick #(
  parameter int unsigned CLK_DIV = 54
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == DW'(CLK_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_bc_tx.sv
module uart_bc_tx
  import uart_bc_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic [1:0] char_len,
  output logic       busy,
  output logic       done,
  output logic       txd
);
  localparam int unsigned CW = $clog2(OSR);

  logic [7:0]    sh;
  logic [3:0]    idx;
  logic [3:0]    nb;
  logic [CW-1:0] tc;
  logic          bit_end;

  assign bit_end = busy && tick && (tc == CW'(OSR - 1));
  assign done    = bit_end && (idx == nb + 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      idx  <= '0;
      nb   <= 4'd8;
      tc   <= '0;
      txd  <= 1'b1;
    end else begin
      txd <= busy ? frame_bit(sh, idx, nb) : 1'b1;
      if (!busy) begin
        if (load) begin
          busy <= 1'b1;
          sh   <= char_mask(load_data, char_len);
          nb   <= char_bits(char_len);
          idx  <= '0;
          tc   <= '0;
        end
      end else if (tick) begin
        if (bit_end) begin
          tc <= '0;
          if (done) busy <= 1'b0;
          else      idx  <= idx + 4'd1;
        end else begin
          tc <= tc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_bc_rx.sv
module uart_bc_rx
  import uart_bc_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic [1:0] char_len,
  input  logic       rxd,
  output logic       valid,
  output logic [7:0] data
);
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned HALF = OSR / 2 - 1;

  rx_state_e     st;
  logic [1:0]    sync;
  logic          rx_s;
  logic [CW-1:0] tc;
  logic [3:0]    bc;
  logic [3:0]    nb;
  logic [1:0]    len_l;
  logic [7:0]    sh;

  assign rx_s = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      tc    <= '0;
      bc    <= '0;
      nb    <= 4'd8;
      len_l <= 2'd3;
      sh    <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      if (!enable) begin
        st <= RX_IDLE;
      end else if (tick) begin
        case (st)
          RX_IDLE: if (!rx_s) begin
            st    <= RX_START;
            tc    <= '0;
            len_l <= char_len;
            nb    <= char_bits(char_len);
          end
          RX_START: if (tc == CW'(HALF)) begin
            tc <= '0;
            bc <= '0;
            st <= rx_s ? RX_IDLE : RX_DATA;
          end else tc <= tc + 1'b1;
          RX_DATA: if (tc == CW'(OSR - 1)) begin
            tc <= '0;
            sh <= {rx_s, sh[7:1]};
            bc <= bc + 4'd1;
            if (bc + 4'd1 == nb) st <= RX_STOP;
          end else tc <= tc + 1'b1;
          RX_STOP: if (tc == CW'(OSR - 1)) begin
            tc    <= '0;
            st    <= RX_IDLE;
            valid <= 1'b1;
            data  <= rx_align(sh, len_l);
          end else tc <= tc + 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_bc_fifo.sv
module uart_bc_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               pdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != NW'(DEPTH)) || do_pop);
  assign head    = (count != '0) ? mem[rp] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (!flush && do_push && wp == PW'(i)) mem[i] <= pdata;
    end
  end
endmodule

// File: rtl/uart_bc_top.sv
module uart_bc_top
  import uart_bc_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 54,
  parameter int unsigned OSR      = 16,
  parameter int unsigned RX_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic [1:0] char_len,
  input  logic       txc_ack,
  input  logic       rxd,
  output logic       txd
);
  localparam int unsigned NW = $clog2(RX_DEPTH + 1);

  logic          tick;
  logic [7:0]    thr_data;
  logic          thr_full;
  logic          tx_load, tx_busy, tx_done;
  logic          rx_push;
  logic [7:0]    rx_char;
  logic [7:0]    fifo_head;
  logic [NW-1:0] fifo_cnt;
  logic          udre, txc, rxc;
  logic          data_wr, txc_set, txc_clr, data_pop;

  assign data_wr  = bus_wr && !bus_addr;
  assign data_pop = bus_rd && !bus_addr;
  assign tx_load  = tx_en && thr_full && !tx_busy;
  assign txc_set  = tx_done && !thr_full;
  assign txc_clr  = txc_ack || (bus_wr && bus_addr && bus_wdata[6]);
  assign udre     = !thr_full;
  assign rxc      = (fifo_cnt != '0);

  assign bus_rdata = bus_addr ? {rxc, txc, udre, 5'b00000} : fifo_head;

  uart_bc_tick #(.CLK_DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_data <= '0;
      thr_full <= 1'b0;
    end else if (data_wr && !thr_full) begin
      thr_data <= bus_wdata;
      thr_full <= 1'b1;
    end else if (tx_load) begin
      thr_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       txc <= 1'b0;
    else if (txc_set) txc <= 1'b1;
    else if (txc_clr) txc <= 1'b0;
  end

  uart_bc_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load), .load_data(thr_data),
    .char_len(char_len), .busy(tx_busy), .done(tx_done), .txd(txd)
  );

  uart_bc_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(rx_en), .char_len(char_len),
    .rxd(rxd), .valid(rx_push), .data(rx_char)
  );

  uart_bc_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(rx_push), .pdata(rx_char),
    .pop(data_pop), .head(fifo_head), .count(fifo_cnt)
  );
endmodule

// File: rtl/uart_bc_chk.sv
module uart_bc_chk #(
  parameter int unsigned NW = 2,
  parameter int unsigned RX_DEPTH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          rx_en,
  input logic          txd,
  input logic          udre,
  input logic          txc,
  input logic          rxc,
  input logic          thr_full,
  input logic [7:0]    thr_data,
  input logic          tx_busy,
  input logic          tx_done,
  input logic          rx_push,
  input logic [NW-1:0] fifo_cnt
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r2_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && !udre) |=> $stable(thr_data));
  a_r3_udre_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && udre) |=> !udre);
  a_r3_udre_rises_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udre) |-> $rose(tx_busy));
  a_r4_txc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !thr_full) |=> txc);
  a_r4_txc_only_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc) |-> $past(tx_done));
  a_r7_push_sets_rxc: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_en) |=> rxc);
  a_r6_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr && fifo_cnt == NW'(1) && !rx_push && rx_en) |=> !rxc);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= NW'(RX_DEPTH));
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rxc && fifo_cnt == '0));
endmodule

bind uart_bc_top uart_bc_chk #(.NW(NW), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .rx_en(rx_en), .txd(txd), .udre(udre), .txc(txc), .rxc(rxc), .thr_full(thr_full),
  .thr_data(thr_data), .tx_busy(tx_busy), .tx_done(tx_done), .rx_push(rx_push),
  .fifo_cnt(fifo_cnt)
);

// File: tb/uart_bc_top_test.sv
module uart_bc_top_test;
  localparam int DIV  = 2;
  localparam int BITC = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_en = 1'b0, rx_en = 1'b0, txc_ack = 1'b0, rxd = 1'b1;
  logic [1:0] char_len = 2'd3;
  logic       txd;

  int checks = 0, fails = 0;
  int txc_seen = 0;
  logic watch_txc = 1'b0;

  always #4 clk = ~clk;

  uart_bc_top #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_en(tx_en), .rx_en(rx_en),
    .char_len(char_len), .txc_ack(txc_ack), .rxd(rxd), .txd(txd)
  );

  function automatic int nbits(input logic [1:0] l);
    return int'(l) + 5;
  endfunction

  function automatic logic [7:0] keep_low(input logic [7:0] d, input logic [1:0] l);
    logic [7:0] r = '0;
    for (int i = 0; i < nbits(l); i++) r[i] = d[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic status(output logic [7:0] s);
    @(negedge clk);
    bus_addr = 1'b1;
    #1 s = bus_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_data(output logic [7:0] d);
    @(negedge clk);
    bus_addr = 1'b0; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic line_send(input logic [7:0] d, input logic [1:0] l);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < nbits(l); i++) begin
      rxd = d[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BITC) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic line_recv(input logic [1:0] l, output logic [7:0] d, output bit stop_ok);
    int t = 0;
    d = '0;
    @(negedge clk);
    while (txd === 1'b1 && t < 40 * BITC) begin
      @(negedge clk);
      t++;
    end
    repeat (BITC / 2) @(negedge clk);
    for (int i = 0; i < nbits(l); i++) begin
      repeat (BITC) @(negedge clk);
      d[i] = txd;
    end
    repeat (BITC) @(negedge clk);
    stop_ok = (txd === 1'b1);
    repeat (BITC) @(negedge clk);
  endtask

  always @(negedge clk) if (watch_txc && bus_addr && bus_rdata[6]) txc_seen++;

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] s, d, e;
    bit so;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    status(s);
    check(s == 8'h20, "R11 reset status", s, 8'h20);
    check(txd === 1'b1, "R11 txd idle after reset", txd, 1);

    // R2/R3: write with transmitter disabled, then an ignored write
    char_len = 2'd3;
    wr(1'b0, 8'hA5);
    status(s);
    check(s[5] == 1'b0, "R3 udre low after accepted write", s[5], 0);
    wr(1'b0, 8'h3C);
    repeat (BITC) @(negedge clk);
    check(txd === 1'b1, "R3 no transfer while tx_en low", txd, 1);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    status(s);
    check(s[5] == 1'b1, "R3 udre high after transfer", s[5], 1);
    line_recv(2'd3, d, so);
    check(d == 8'hA5, "R2 ignored write, pending char sent", d, 8'hA5);
    check(so, "R1 stop bit high", so, 1);
    repeat (BITC) @(negedge clk);
    status(s);
    check(s[6] == 1'b1, "R4 txc set after frame", s, 8'h60);
    wr(1'b1, 8'h40);
    status(s);
    check(s[6] == 1'b0, "R4 txc cleared by status write", s[6], 0);

    // R5 short transmit ignores upper bits
    char_len = 2'd0;
    wr(1'b0, 8'hE5);
    line_recv(2'd0, d, so);
    check(d == 8'h05 && so, "R5 5-bit tx upper ignored, stop after 5 bits", d, 8'h05);
    repeat (BITC) @(negedge clk);
    @(negedge clk); txc_ack = 1'b1;
    @(negedge clk); txc_ack = 1'b0;
    status(s);
    check(s[6] == 1'b0, "R4 txc cleared by ack", s[6], 0);

    // R4 set versus held acknowledge in the same cycle
    char_len = 2'd3;
    wr(1'b0, 8'h5A);
    @(negedge clk);
    bus_addr = 1'b1; txc_ack = 1'b1; txc_seen = 0; watch_txc = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    watch_txc = 1'b0; txc_ack = 1'b0;
    check(txc_seen == 1, "R4 set wins over held ack for one cycle", txc_seen, 1);

    // R1 random transmit
    for (int k = 0; k < 8; k++) begin
      char_len = 2'($urandom_range(0, 3));
      e = 8'($urandom);
      wr(1'b0, e);
      line_recv(char_len, d, so);
      check(d == keep_low(e, char_len) && so, "R1 random tx char", d, keep_low(e, char_len));
    end
    repeat (BITC) @(negedge clk);

    // R6/R7 receive path
    rx_en = 1'b1;
    char_len = 2'd3;
    repeat (4) @(negedge clk);
    status(s);
    check(s[7] == 1'b0, "R7 rxc low when empty", s[7], 0);
    line_send(8'h96, 2'd3);
    status(s);
    check(s[7] == 1'b1, "R7 rxc high with data", s[7], 1);
    rd_data(d);
    check(d == 8'h96, "R6 read returns received char", d, 8'h96);
    status(s);
    check(s[7] == 1'b0, "R6 pop empties fifo", s[7], 0);

    // R5 receiver zeroes upper bits
    char_len = 2'd1;
    line_send(8'hFF, 2'd1);
    rd_data(d);
    check(d == 8'h3F, "R5 6-bit rx upper zero", d, 8'h3F);

    // R8 overflow drop, R6 order
    char_len = 2'd3;
    line_send(8'h11, 2'd3);
    line_send(8'h22, 2'd3);
    line_send(8'h33, 2'd3);
    rd_data(d);
    check(d == 8'h11, "R6 oldest first", d, 8'h11);
    rd_data(d);
    check(d == 8'h22, "R8 second kept", d, 8'h22);
    status(s);
    check(s[7] == 1'b0, "R8 third char dropped", s[7], 0);

    // R9 flush on disable
    line_send(8'h44, 2'd3);
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk);
    status(s);
    check(s[7] == 1'b0, "R9 flush clears rxc", s[7], 0);
    rx_en = 1'b1;
    rd_data(d);
    check(d == 8'h00, "R9 fifo empty after flush", d, 0);

    // R10 glitch rejected, then a real char
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    status(s);
    check(s[7] == 1'b0, "R10 short low pulse rejected", s[7], 0);
    line_send(8'hC3, 2'd3);
    rd_data(d);
    check(d == 8'hC3, "R10 receiver recovers after glitch", d, 8'hC3);

    // R5/R6 random receive
    for (int k = 0; k < 10; k++) begin
      char_len = 2'($urandom_range(0, 3));
      e = 8'($urandom);
      line_send(e, char_len);
      rd_data(d);
      check(d == keep_low(e, char_len), "R6 random rx char", d, keep_low(e, char_len));
    end

    status(s);
    check(s[4:0] == 5'd0, "R11 unused status bits zero", s, {s[7:5], 5'd0});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule